// File: doc/BRIEF.md
# ATA Device Status and Interrupt Sequencer

This block keeps the status byte, the error byte, the device-control byte and the signature-bearing task-file registers of a single ATA or packet (ATAPI) device. It also decides when the host sees the handshake for a command. A command decoder elsewhere in the device reports internal events on a small operation code: command accepted, completion, data ready, fast completion, fast data ready, and abort with an error code. The sequencer turns each of these into the right BSY, DRQ and ERR pattern, and it raises the interrupt request only after a short delay measured in system tick enables.

The host reaches the block through register reads and writes. A status read acknowledges the interrupt. An alternate-status read shows the same byte and leaves the interrupt alone. While the device is busy, every task-file read returns the status byte. Setting the reset bit of the device-control register starts a soft reset. The soft reset loads a signature that tells a disk device from a packet device, and the block emits a one-cycle pulse so that the rest of the device can reinitialise.

Top module: `ata_status_seq`

## Requirements
- R1: After synchronous reset the irq line is low, the error byte reads 0x00, and a status read returns 0x50 for a disk device or 0x00 for a packet device. The status byte has ERR at bit 0, DRQ at bit 3, DSC at bit 4, DRDY at bit 6 and BSY at bit 7.
- R2: A completion event (op 2) sets BSY and clears DRQ. After two tick enables, BSY clears and irq rises on the second one.
- R3: A fast completion (op 4) behaves like a completion but ends after one tick enable.
- R4: Data-ready events (op 3, op 5) arm a pending flag, and DRQ is set when the delay ends. A completion without the flag ends with DRQ clear. DRQ and BSY are never set together.
- R5: While device-control bit 1 is set, irq stays low, and an interrupt that ended under the mask does not appear when the mask is later cleared.
- R6: A read of the status location (address 7) clears irq. A read of the alternate-status location (address 8) returns the same byte and leaves irq unchanged.
- R7: While BSY is set, a read of any task-file address 0 to 7 returns the status byte.
- R8: Writing device-control with bit 2 rising from 0 to 1 pulses srst_o for one cycle. It loads sector count 1, sector 1 and error 0x01, and it loads cylinder low/high 0x00/0x00 for a disk device or 0x14/0xEB for a packet device. It clears BSY, DRQ and ERR. A write with bit 2 already set does nothing of this.
- R9: Any write to addresses 0 to 7 clears device-control bit 7 and leaves its other bits unchanged.
- R10: A command-accepted event (op 1) clears DRQ and ERR and zeroes the error byte. A packet device reports DRDY and DSC only after its first accepted command, and a soft reset withdraws them again.
- R11: An abort (op 6) ORs abort_code into the error byte, sets ERR and starts a two-tick interrupt. In the error byte, ABRT is bit 2 and IDNF is bit 4.
- R12: A new interrupt request that arrives while the delay is running reloads the delay.
- R13: The delay counts only cycles in which tick_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | System tick enable that paces the interrupt delay |
| is_packet | input | 1 | 1 for a packet device, 0 for a disk device |
| ev_op | input | 3 | Internal event: 0 none, 1 accepted, 2 complete, 3 data ready, 4 fast complete, 5 fast data ready, 6 abort |
| abort_code | input | 8 | Error bits ORed in on an abort |
| reg_rd | input | 1 | Host register read strobe |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Register address: 0 data, 1 error, 2 count, 3 sector, 4 cyl low, 5 cyl high, 6 select, 7 status/command, 8 control/alt-status |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data for the current address (combinational) |
| status_o | output | 8 | Status byte as the host would read it |
| error_o | output | 8 | Error byte |
| devctl_o | output | 8 | Device-control byte |
| irq_o | output | 1 | Interrupt request, gated by the mask bit |
| srst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
An event or a register write takes effect at the next clock edge, so status, error, devctl_o and srst_o are due one cycle after their stimulus. The end of an interrupt delay is due at the edge of the second tick enable, or the first for the fast path. The bench drives every input just after a falling edge and samples at the following falling edge, which puts each result one full register stage after its cause. Read data is combinational and is sampled while the read strobe is held. The effect of that read on irq is sampled one edge later.

// File: rtl/ata_stat_pkg.sv
package ata_stat_pkg;

    localparam int ST_ERR  = 0;
    localparam int ST_DRQ  = 3;
    localparam int ST_DSC  = 4;
    localparam int ST_DRDY = 6;
    localparam int ST_BSY  = 7;

    localparam int ER_ABRT = 2;
    localparam int ER_IDNF = 4;

    localparam int DC_MASK = 1;
    localparam int DC_SRST = 2;
    localparam int DC_HIGH = 7;

    typedef enum logic [2:0] {
        EV_NONE      = 3'd0,
        EV_ACCEPT    = 3'd1,
        EV_DONE      = 3'd2,
        EV_DATA      = 3'd3,
        EV_FAST      = 3'd4,
        EV_FAST_DATA = 3'd5,
        EV_ABORT     = 3'd6
    } ev_e;

    typedef enum logic [3:0] {
        RA_DATA    = 4'd0,
        RA_ERROR   = 4'd1,
        RA_COUNT   = 4'd2,
        RA_SECTOR  = 4'd3,
        RA_CYL_LO  = 4'd4,
        RA_CYL_HI  = 4'd5,
        RA_SELECT  = 4'd6,
        RA_STATUS  = 4'd7,
        RA_CONTROL = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [7:0] count;
        logic [7:0] sector;
        logic [7:0] cyl_lo;
        logic [7:0] cyl_hi;
        logic [7:0] select;
    } taskfile_t;

    function automatic taskfile_t reset_signature(input logic packet, input logic [7:0] sel);
        taskfile_t t;
        t.count  = 8'h01;
        t.sector = 8'h01;
        t.cyl_lo = packet ? 8'h14 : 8'h00;
        t.cyl_hi = packet ? 8'hEB : 8'h00;
        t.select = sel;
        return t;
    endfunction

    function automatic logic [7:0] pack_status(input logic bsy, input logic ready,
                                               input logic drq, input logic err);
        logic [7:0] s;
        s          = '0;
        s[ST_BSY]  = bsy;
        s[ST_DRDY] = ready;
        s[ST_DSC]  = ready;
        s[ST_DRQ]  = drq;
        s[ST_ERR]  = err;
        return s;
    endfunction

    function automatic logic is_taskfile(input logic [3:0] a);
        return a <= 4'(RA_STATUS);
    endfunction

endpackage

// File: rtl/ata_irq_delay.sv
module ata_irq_delay
    import ata_stat_pkg::*;
#(
    parameter int NORM_TICKS = 2,
    parameter int FAST_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load_norm,
    input  logic load_fast,
    input  logic cancel,
    input  logic tick_en,
    output logic running,
    output logic done
);
    localparam int MAX_TICKS = (NORM_TICKS > FAST_TICKS) ? NORM_TICKS : FAST_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] cnt_q;

    assign running = (cnt_q != '0);
    assign done    = tick_en && (cnt_q == CW'(1)) && !load_norm && !load_fast && !cancel;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            cnt_q <= '0;
        end else if (load_norm) begin
            cnt_q <= CW'(NORM_TICKS);
        end else if (load_fast) begin
            cnt_q <= CW'(FAST_TICKS);
        end else if (tick_en && running) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
    import ata_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       is_packet,
    input  logic       reg_wr,
    input  logic [3:0] reg_addr,
    input  logic [7:0] wr_data,
    output taskfile_t  tf,
    output logic [7:0] devctl,
    output logic       srst_now
);
    taskfile_t  tf_q;
    logic [7:0] dc_q;
    logic       ctrl_wr;

    assign ctrl_wr  = reg_wr && (reg_addr == 4'(RA_CONTROL));
    assign srst_now = ctrl_wr && wr_data[DC_SRST] && !dc_q[DC_SRST];
    assign tf       = tf_q;
    assign devctl   = dc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tf_q <= '0;
            dc_q <= '0;
        end else if (ctrl_wr) begin
            dc_q <= wr_data;
            if (srst_now) begin
                tf_q <= reset_signature(is_packet, tf_q.select);
            end
        end else if (reg_wr && is_taskfile(reg_addr)) begin
            dc_q[DC_HIGH] <= 1'b0;
            case (reg_addr)
                4'(RA_COUNT):  tf_q.count  <= wr_data;
                4'(RA_SECTOR): tf_q.sector <= wr_data;
                4'(RA_CYL_LO): tf_q.cyl_lo <= wr_data;
                4'(RA_CYL_HI): tf_q.cyl_hi <= wr_data;
                4'(RA_SELECT): tf_q.select <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ata_read_mux.sv
module ata_read_mux
    import ata_stat_pkg::*;
(
    input  logic [3:0] reg_addr,
    input  logic [7:0] status,
    input  logic [7:0] error,
    input  taskfile_t  tf,
    output logic [7:0] rd_data
);
    always_comb begin
        if (status[ST_BSY] && is_taskfile(reg_addr)) begin
            rd_data = status;
        end else begin
            case (reg_addr)
                4'(RA_DATA):    rd_data = 8'h00;
                4'(RA_ERROR):   rd_data = error;
                4'(RA_COUNT):   rd_data = tf.count;
                4'(RA_SECTOR):  rd_data = tf.sector;
                4'(RA_CYL_LO):  rd_data = tf.cyl_lo;
                4'(RA_CYL_HI):  rd_data = tf.cyl_hi;
                4'(RA_SELECT):  rd_data = tf.select;
                4'(RA_STATUS),
                4'(RA_CONTROL): rd_data = status;
                default:        rd_data = 8'hFF;
            endcase
        end
    end
endmodule

// File: rtl/ata_status_seq.sv
module ata_status_seq
    import ata_stat_pkg::*;
#(
    parameter int NORM_TICKS = 2,
    parameter int FAST_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       is_packet,
    input  logic [2:0] ev_op,
    input  logic [7:0] abort_code,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [3:0] reg_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [7:0] status_o,
    output logic [7:0] error_o,
    output logic [7:0] devctl_o,
    output logic       irq_o,
    output logic       srst_o
);
    ev_e        ev;
    logic       bsy_q, drq_q, err_q, pend_q, irq_q, seen_cmd_q, srst_q;
    logic [7:0] error_q;
    logic       srst_now, load_norm, load_fast, running, done, ack_read;
    taskfile_t  tf;
    logic [7:0] devctl;

    assign ev        = ev_e'(ev_op);
    assign load_norm = (ev == EV_DONE) || (ev == EV_DATA) || (ev == EV_ABORT);
    assign load_fast = (ev == EV_FAST) || (ev == EV_FAST_DATA);

    ata_taskfile u_tf (
        .clk(clk), .rst(rst), .is_packet(is_packet), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .wr_data(wr_data), .tf(tf), .devctl(devctl),
        .srst_now(srst_now)
    );

    ata_irq_delay #(.NORM_TICKS(NORM_TICKS), .FAST_TICKS(FAST_TICKS)) u_dly (
        .clk(clk), .rst(rst), .load_norm(load_norm), .load_fast(load_fast),
        .cancel(srst_now), .tick_en(tick_en), .running(running), .done(done)
    );

    assign status_o = pack_status(bsy_q, !is_packet || seen_cmd_q, drq_q, err_q);

    ata_read_mux u_mux (
        .reg_addr(reg_addr), .status(status_o), .error(error_q), .tf(tf),
        .rd_data(rd_data)
    );

    // a status read, including one redirected there while busy, acknowledges
    assign ack_read = reg_rd && ((reg_addr == 4'(RA_STATUS)) ||
                                 (bsy_q && is_taskfile(reg_addr)));

    always_ff @(posedge clk) begin
        if (rst) begin
            bsy_q <= 1'b0; drq_q <= 1'b0; err_q <= 1'b0; pend_q <= 1'b0;
            irq_q <= 1'b0; seen_cmd_q <= 1'b0; error_q <= '0; srst_q <= 1'b0;
        end else if (srst_now) begin
            bsy_q <= 1'b0; drq_q <= 1'b0; err_q <= 1'b0; pend_q <= 1'b0;
            irq_q <= 1'b0; seen_cmd_q <= 1'b0; error_q <= 8'h01; srst_q <= 1'b1;
        end else begin
            srst_q <= 1'b0;
            if (ack_read) irq_q <= 1'b0;
            case (ev)
                EV_ACCEPT: begin
                    drq_q <= 1'b0; err_q <= 1'b0; error_q <= '0; seen_cmd_q <= 1'b1;
                end
                EV_DONE, EV_FAST: begin
                    bsy_q <= 1'b1; drq_q <= 1'b0;
                end
                EV_DATA, EV_FAST_DATA: begin
                    bsy_q <= 1'b1; drq_q <= 1'b0; pend_q <= 1'b1;
                end
                EV_ABORT: begin
                    bsy_q <= 1'b1; drq_q <= 1'b0; err_q <= 1'b1;
                    error_q <= error_q | abort_code;
                end
                default: ;
            endcase
            if (done) begin
                bsy_q  <= 1'b0;
                drq_q  <= pend_q;
                pend_q <= 1'b0;
                if (!devctl[DC_MASK]) irq_q <= 1'b1;
            end
        end
    end

    assign error_o  = error_q;
    assign devctl_o = devctl;
    assign irq_o    = irq_q && !devctl[DC_MASK];
    assign srst_o   = srst_q;

endmodule

// File: rtl/ata_status_seq_chk.sv
module ata_status_seq_chk
    import ata_stat_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [3:0] reg_addr,
    input logic [7:0] rd_data,
    input logic [7:0] status_o,
    input logic [7:0] devctl_o,
    input logic       irq_o,
    input logic       srst_o
);
    // R4: data request never shown together with busy
    a_r4_no_drq_while_busy: assert property (@(posedge clk) disable iff (rst)
        !(status_o[ST_BSY] && status_o[ST_DRQ]));

    // R5: masked device never drives the line
    a_r5_mask_gates_irq: assert property (@(posedge clk) disable iff (rst)
        devctl_o[DC_MASK] |-> !irq_o);

    // R6: status read acknowledges when not busy
    a_r6_status_read_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 4'(RA_STATUS) && !status_o[ST_BSY]) |=> !irq_o);

    // R6: alternate-status read leaves the line alone
    a_r6_alt_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == 4'(RA_CONTROL) && irq_o) |=> irq_o);

    // R7: busy redirects task-file reads to status
    a_r7_busy_redirect: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && status_o[ST_BSY] && reg_addr <= 4'(RA_STATUS)) |-> rd_data == status_o);

    // R8: the soft-reset pulse comes with a cleared, quiet device
    a_r8_srst_quiet: assert property (@(posedge clk) disable iff (rst)
        srst_o |-> (!status_o[ST_BSY] && !status_o[ST_DRQ] && !status_o[ST_ERR] && !irq_o));

    // R2: end of busy without soft reset raises the unmasked line
    a_r2_busy_end_irq: assert property (@(posedge clk) disable iff (rst)
        ($fell(status_o[ST_BSY]) && !srst_o && !devctl_o[DC_MASK] && $stable(devctl_o[DC_MASK]))
        |-> irq_o);
endmodule

bind ata_status_seq ata_status_seq_chk u_chk (.*);

// File: tb/ata_status_seq_tb.sv
`timescale 1ns/1ps
module ata_status_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       is_packet = 1'b0;
    logic [2:0] ev_op = 3'd0;
    logic [7:0] abort_code = 8'h00;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, status_o, error_o, devctl_o;
    logic       irq_o, srst_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ata_status_seq u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .is_packet(is_packet),
        .ev_op(ev_op), .abort_code(abort_code), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .status_o(status_o), .error_o(error_o), .devctl_o(devctl_o),
        .irq_o(irq_o), .srst_o(srst_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic pkt);
        @(negedge clk);
        rst = 1'b1; is_packet = pkt;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ev(input logic [2:0] op, input logic [7:0] code);
        ev_op = op; abort_code = code;
        @(negedge clk);
        ev_op = 3'd0; abort_code = 8'h00;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        do_reset(1'b0);
        chk("R1 disk status", status_o, 8'h50);
        chk("R1 irq low", {7'd0, irq_o}, 8'h00);
        rd(4'd1, d); chk("R1 error byte", d, 8'h00);
        do_reset(1'b1);
        rd(4'd7, d); chk("R1 packet status", d, 8'h00);
        do_reset(1'b0);
    endtask

    task automatic t_normal_and_ack();
        logic [7:0] d;
        ev(3'd2, 8'h00);
        chk("R2 busy after complete", status_o, 8'hD0);
        idle(3);
        chk("R13 no tick keeps busy", status_o, 8'hD0);
        ticks(1);
        chk("R2 busy after one tick", status_o, 8'hD0);
        chk("R2 irq still low", {7'd0, irq_o}, 8'h00);
        ticks(1);
        chk("R2 idle after two ticks", status_o, 8'h50);
        chk("R2 irq raised", {7'd0, irq_o}, 8'h01);
        rd(4'd8, d);
        chk("R6 alt-status value", d, 8'h50);
        chk("R6 alt-status keeps irq", {7'd0, irq_o}, 8'h01);
        rd(4'd7, d);
        chk("R6 status value", d, 8'h50);
        chk("R6 status read clears irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_fast();
        logic [7:0] d;
        ev(3'd4, 8'h00);
        chk("R3 busy after fast", status_o, 8'hD0);
        ticks(1);
        chk("R3 done after one tick", status_o, 8'h50);
        chk("R3 irq raised", {7'd0, irq_o}, 8'h01);
        rd(4'd7, d);
    endtask

    task automatic t_data();
        logic [7:0] d;
        ev(3'd3, 8'h00);
        ticks(2);
        chk("R4 drq after data ready", status_o, 8'h58);
        rd(4'd7, d);
        ev(3'd2, 8'h00);
        chk("R4 busy clears drq", status_o, 8'hD0);
        ticks(2);
        chk("R4 plain completion no drq", status_o, 8'h50);
        rd(4'd7, d);
        ev(3'd5, 8'h00);
        ticks(1);
        chk("R4 fast data drq", status_o, 8'h58);
        rd(4'd7, d);
        ev(3'd1, 8'h00);
        chk("R10 accept clears drq", status_o, 8'h50);
    endtask

    task automatic t_mask();
        wr(4'd8, 8'h02);
        ev(3'd2, 8'h00);
        ticks(2);
        chk("R5 masked completion status", status_o, 8'h50);
        chk("R5 irq held low", {7'd0, irq_o}, 8'h00);
        wr(4'd8, 8'h00);
        chk("R5 unmask shows no stale irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_redirect();
        logic [7:0] d;
        wr(4'd2, 8'h33);
        ev(3'd2, 8'h00);
        rd(4'd2, d);
        chk("R7 busy read redirected", d, 8'hD0);
        ticks(2);
        rd(4'd2, d);
        chk("R7 idle read of count", d, 8'h33);
        rd(4'd7, d);
    endtask

    task automatic t_reload();
        logic [7:0] d;
        ev(3'd2, 8'h00);
        ticks(1);
        ev(3'd2, 8'h00);
        ticks(1);
        chk("R12 reload extends busy", status_o, 8'hD0);
        ticks(1);
        chk("R12 ends after reload", status_o, 8'h50);
        rd(4'd7, d);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        ev(3'd1, 8'h00);
        ev(3'd6, 8'h04);
        chk("R11 abort busy with err", status_o, 8'hD1);
        ticks(1);
        chk("R11 still busy after one tick", status_o, 8'hD1);
        ticks(1);
        chk("R11 abort ends", status_o, 8'h51);
        chk("R11 abort irq", {7'd0, irq_o}, 8'h01);
        rd(4'd1, d); chk("R11 abort code", d, 8'h04);
        rd(4'd7, d);
        ev(3'd6, 8'h10);
        ticks(2);
        rd(4'd1, d); chk("R11 codes accumulate", d, 8'h14);
        rd(4'd7, d);
        ev(3'd1, 8'h00);
        chk("R10 accept clears err", status_o, 8'h50);
        rd(4'd1, d); chk("R10 accept zeroes error", d, 8'h00);
    endtask

    task automatic t_soft_reset();
        logic [7:0] d;
        wr(4'd2, 8'h05);
        wr(4'd4, 8'h07);
        wr(4'd8, 8'h04);
        chk("R8 pulse", {7'd0, srst_o}, 8'h01);
        idle(1);
        chk("R8 pulse one cycle", {7'd0, srst_o}, 8'h00);
        rd(4'd2, d); chk("R8 count sig", d, 8'h01);
        rd(4'd3, d); chk("R8 sector sig", d, 8'h01);
        rd(4'd4, d); chk("R8 disk cyl lo", d, 8'h00);
        rd(4'd5, d); chk("R8 disk cyl hi", d, 8'h00);
        rd(4'd1, d); chk("R8 error sig", d, 8'h01);
        chk("R8 disk status", status_o, 8'h50);
        wr(4'd2, 8'h09);
        wr(4'd8, 8'h04);
        chk("R8 no pulse without rise", {7'd0, srst_o}, 8'h00);
        rd(4'd2, d); chk("R8 no reload without rise", d, 8'h09);
        do_reset(1'b1);
        ev(3'd1, 8'h00);
        chk("R10 packet ready after accept", status_o, 8'h50);
        ev(3'd2, 8'h00);
        wr(4'd8, 8'h04);
        chk("R8 reset cancels busy", status_o, 8'h00);
        rd(4'd4, d); chk("R8 packet cyl lo", d, 8'h14);
        rd(4'd5, d); chk("R8 packet cyl hi", d, 8'hEB);
        ticks(3);
        chk("R8 no late completion", status_o, 8'h00);
        chk("R8 no late irq", {7'd0, irq_o}, 8'h00);
        do_reset(1'b0);
    endtask

    task automatic t_high_byte();
        wr(4'd8, 8'h80);
        chk("R9 control bit 7 set", devctl_o, 8'h80);
        wr(4'd3, 8'h11);
        chk("R9 task-file write clears bit 7", devctl_o, 8'h00);
        wr(4'd8, 8'h82);
        wr(4'd7, 8'hEC);
        chk("R9 command write keeps others", devctl_o, 8'h02);
        wr(4'd8, 8'h00);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_normal_and_ack();
        t_fast();
        t_data();
        t_mask();
        t_redirect();
        t_reload();
        t_abort();
        t_soft_reset();
        t_high_byte();
        idle(2);
        finish_run();
    end
endmodule